// File: doc/BRIEF.md
# Branch and Skip Resolution Unit

This unit resolves the program-counter successor for the conditional control-flow instructions of a small 8-bit RISC core. It covers two kinds of instruction. A relative branch tests one chosen bit of the 8-bit status byte against a polarity bit and adds a signed 7-bit offset when the test holds. A skip tests a register bit, an I/O bit or an external equality result, and steps past the next instruction when its condition holds. That next instruction may be one or two words long.

Instruction decode drives one request per cycle with `req_valid_i`. The unit registers its decision and presents `res_valid_o`, `taken_o` and `next_pc_o` one clock later. Named branch forms are encodings of the generic bit test. "Equal" is bit 1 with polarity 1. "Same or higher" is bit 0 with polarity 0. "Lower" is bit 0 with polarity 1. "Signed greater or equal" is bit 4 with polarity 0. Fetch and pipeline flushing are handled outside the unit.

Top module: `branch_skip_unit`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no request, `res_valid_o`, `taken_o` and `next_pc_o` are all 0.
- R2: `res_valid_o` is high exactly in the cycle after a cycle with `req_valid_i` high, so each result has one cycle of latency.
- R3: With `op_i`=0 (branch), the branch is taken when status bit `bit_sel_i` equals `pol_i`. A taken branch gives `next_pc_o` = pc + offset + 1.
- R4: A branch that is not taken gives `next_pc_o` = pc + 1 and `taken_o` = 0.
- R5: `offset_i` is a 7-bit two's-complement value from -64 to +63. All PC arithmetic wraps modulo 2^PC_W.
- R6: The status byte holds its flags in this order from bit 7 down to bit 0: I, T, H, S, V, N, Z, C. Named branch conditions use these positions: Z is bit 1, C is bit 0 and S is bit 4.
- R7: With `op_i`=1 (register-bit skip), the skip is taken when `reg_byte_i[bit_sel_i]` equals `pol_i`. A taken skip gives pc + 3 when `next_two_word_i` is 1, and pc + 2 otherwise.
- R8: With `op_i`=2 (I/O-bit skip), the test uses `io_byte_i` the same way that R7 uses the register byte. `reg_byte_i` has no effect on this test.
- R9: With `op_i`=3 (compare skip), the skip is taken exactly when `eq_i` is 1. `pol_i` and `bit_sel_i` have no effect on this test.
- R10: A skip that is not taken gives pc + 1, whatever the value of `next_two_word_i`.
- R11: In a cycle after `req_valid_i` was low, `taken_o` and `next_pc_o` keep their previous values.
- R12: A branch ignores `next_two_word_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is present this cycle |
| op_i | input | 2 | 0 branch, 1 register-bit skip, 2 I/O-bit skip, 3 compare skip |
| pol_i | input | 1 | Bit value that satisfies the test |
| bit_sel_i | input | 3 | Index of the bit under test |
| sreg_i | input | 8 | Status byte (I,T,H,S,V,N,Z,C from bit 7 to bit 0) |
| reg_byte_i | input | 8 | Register operand for register-bit skips |
| io_byte_i | input | 8 | I/O operand for I/O-bit skips |
| eq_i | input | 1 | Register-equality result for compare skips |
| offset_i | input | 7 | Signed branch offset |
| pc_i | input | PC_W | PC of the current instruction |
| next_two_word_i | input | 1 | The following instruction is two words long |
| res_valid_o | output | 1 | A result is valid |
| taken_o | output | 1 | The condition held |
| next_pc_o | output | PC_W | Resolved successor PC |

## Verification
Some properties are checked by assertions on every cycle. These are the one-cycle valid handshake, the hold of results across idle cycles, the pc + 1 step of every untaken request, the 2-or-3 step of taken skips and the equality-only decision of compare skips. Other behaviour can only be shown by the bench's directed scenarios. These are the status-bit positions of the named aliases, offset extremes that wrap at both ends of the PC space, and skips whose unused operand or polarity is set to contradict the result.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  typedef enum logic [1:0] {
    OP_BRANCH  = 2'd0,
    OP_SKIP_RB = 2'd1,
    OP_SKIP_IO = 2'd2,
    OP_SKIP_EQ = 2'd3
  } bsu_op_e;

  localparam int unsigned SR_C = 0;
  localparam int unsigned SR_Z = 1;
  localparam int unsigned SR_N = 2;
  localparam int unsigned SR_V = 3;
  localparam int unsigned SR_S = 4;
  localparam int unsigned SR_H = 5;
  localparam int unsigned SR_T = 6;
  localparam int unsigned SR_I = 7;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SEL_W  = $clog2(BYTE_W);
  localparam int unsigned N_SRC  = 3;
endpackage

// File: rtl/bsu_bit_test.sv
module bsu_bit_test #(
  parameter int unsigned W     = 8,
  parameter int unsigned SEL_W = $clog2(W)
) (
  input  logic [W-1:0]     byte_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             pol_i,
  output logic             hit_o
);
  assign hit_o = (byte_i[sel_i] == pol_i);
endmodule

// File: rtl/bsu_pc_step.sv
module bsu_pc_step #(
  parameter int unsigned PC_W  = 10,
  parameter int unsigned OFF_W = 7
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             two_word_i,
  output logic [PC_W-1:0]  seq_o,
  output logic [PC_W-1:0]  br_o,
  output logic [PC_W-1:0]  skip_o
);
  localparam int unsigned EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] off_ext;
  logic [PC_W-1:0] skip_inc;

  assign off_ext  = {{EXT_W{off_i[OFF_W-1]}}, off_i};
  assign seq_o    = pc_i + PC_W'(1);
  assign br_o     = seq_o + off_ext;
  assign skip_inc = two_word_i ? PC_W'(3) : PC_W'(2);
  assign skip_o   = pc_i + skip_inc;
endmodule

// File: rtl/bsu_decide.sv
module bsu_decide
  import bsu_pkg::*;
#(
  parameter int unsigned PC_W = 10
) (
  input  bsu_op_e          op_i,
  input  logic [N_SRC-1:0] hit_i,
  input  logic             eq_i,
  input  logic [PC_W-1:0]  seq_i,
  input  logic [PC_W-1:0]  br_i,
  input  logic [PC_W-1:0]  skip_i,
  output logic             taken_o,
  output logic [PC_W-1:0]  next_pc_o
);
  always_comb begin
    unique case (op_i)
      OP_BRANCH:  taken_o = hit_i[0];
      OP_SKIP_RB: taken_o = hit_i[1];
      OP_SKIP_IO: taken_o = hit_i[2];
      default:    taken_o = eq_i;
    endcase
    if (!taken_o)                 next_pc_o = seq_i;
    else if (op_i == OP_BRANCH)   next_pc_o = br_i;
    else                          next_pc_o = skip_i;
  end
endmodule

// File: rtl/branch_skip_unit.sv
module branch_skip_unit
  import bsu_pkg::*;
#(
  parameter int unsigned PC_W  = 10,
  parameter int unsigned OFF_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [1:0]      op_i,
  input  logic            pol_i,
  input  logic [2:0]      bit_sel_i,
  input  logic [7:0]      sreg_i,
  input  logic [7:0]      reg_byte_i,
  input  logic [7:0]      io_byte_i,
  input  logic            eq_i,
  input  logic [6:0]      offset_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            next_two_word_i,
  output logic            res_valid_o,
  output logic            taken_o,
  output logic [PC_W-1:0] next_pc_o
);
  logic [N_SRC-1:0][BYTE_W-1:0] src;
  logic [N_SRC-1:0]             hit;
  logic [PC_W-1:0]              seq_pc, br_pc, skip_pc, nxt_pc;
  logic                         nxt_taken;
  bsu_op_e                      op;

  assign op     = bsu_op_e'(op_i);
  assign src[0] = sreg_i;
  assign src[1] = reg_byte_i;
  assign src[2] = io_byte_i;

  for (genvar g = 0; g < N_SRC; g++) begin : g_test
    bsu_bit_test #(.W(BYTE_W), .SEL_W(SEL_W)) u_test (
      .byte_i (src[g]),
      .sel_i  (bit_sel_i),
      .pol_i  (pol_i),
      .hit_o  (hit[g])
    );
  end

  bsu_pc_step #(.PC_W(PC_W), .OFF_W(OFF_W)) u_step (
    .pc_i       (pc_i),
    .off_i      (offset_i),
    .two_word_i (next_two_word_i),
    .seq_o      (seq_pc),
    .br_o       (br_pc),
    .skip_o     (skip_pc)
  );

  bsu_decide #(.PC_W(PC_W)) u_decide (
    .op_i      (op),
    .hit_i     (hit),
    .eq_i      (eq_i),
    .seq_i     (seq_pc),
    .br_i      (br_pc),
    .skip_i    (skip_pc),
    .taken_o   (nxt_taken),
    .next_pc_o (nxt_pc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      taken_o     <= 1'b0;
      next_pc_o   <= '0;
    end else begin
      res_valid_o <= req_valid_i;
      if (req_valid_i) begin
        taken_o   <= nxt_taken;
        next_pc_o <= nxt_pc;
      end
    end
  end

  p_valid_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_o);
  p_valid_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !res_valid_o);
  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(next_pc_o) && $stable(taken_o)));
  p_untaken_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (taken_o || next_pc_o == $past(pc_i) + PC_W'(1)));
  p_skip_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i != 2'd0) |=>
      (!taken_o || next_pc_o == $past(pc_i) + ($past(next_two_word_i) ? PC_W'(3) : PC_W'(2))));
  p_eq_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i == 2'd3) |=> (taken_o == $past(eq_i)));
endmodule

// File: tb/branch_skip_unit_bench.sv
module branch_skip_unit_bench;
  localparam int PC_W = 10;
  localparam int PC_M = 1 << PC_W;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            req_valid_i = 1'b0;
  logic [1:0]      op_i = '0;
  logic            pol_i = 1'b0;
  logic [2:0]      bit_sel_i = '0;
  logic [7:0]      sreg_i = '0, reg_byte_i = '0, io_byte_i = '0;
  logic            eq_i = 1'b0;
  logic [6:0]      offset_i = '0;
  logic [PC_W-1:0] pc_i = '0;
  logic            next_two_word_i = 1'b0;
  logic            res_valid_o, taken_o;
  logic [PC_W-1:0] next_pc_o;

  int checks = 0;
  int bad = 0;

  typedef struct {
    logic  v;
    logic  t;
    int    pc;
    string req;
  } item_t;
  item_t q[$];
  logic  m_taken = 1'b0;
  int    m_pc = 0;

  always #5 clk = ~clk;

  branch_skip_unit #(.PC_W(PC_W)) u_branch_skip_unit (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .op_i(op_i),
    .pol_i(pol_i), .bit_sel_i(bit_sel_i), .sreg_i(sreg_i), .reg_byte_i(reg_byte_i),
    .io_byte_i(io_byte_i), .eq_i(eq_i), .offset_i(offset_i), .pc_i(pc_i),
    .next_two_word_i(next_two_word_i), .res_valid_o(res_valid_o),
    .taken_o(taken_o), .next_pc_o(next_pc_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  // Driver: one item per negedge, expected result computed from the requirements
  task automatic drive(input string req, input int op, input logic pol, input int sel,
                       input logic [7:0] sr, input logic [7:0] rb, input logic [7:0] io,
                       input logic eq, input int off, input int pc, input logic tw);
    item_t it;
    logic  cond;
    @(negedge clk);
    req_valid_i = 1'b1; op_i = op[1:0]; pol_i = pol; bit_sel_i = sel[2:0];
    sreg_i = sr; reg_byte_i = rb; io_byte_i = io; eq_i = eq;
    offset_i = off[6:0]; pc_i = pc[PC_W-1:0]; next_two_word_i = tw;
    case (op)
      0: cond = (sr[sel] == pol);
      1: cond = (rb[sel] == pol);
      2: cond = (io[sel] == pol);
      default: cond = eq;
    endcase
    if (!cond)        it.pc = (pc + 1) % PC_M;
    else if (op == 0) it.pc = ((pc + off + 1) % PC_M + PC_M) % PC_M;
    else              it.pc = (pc + (tw ? 3 : 2)) % PC_M;
    it.v = 1'b1; it.t = cond; it.req = req;
    m_taken = cond; m_pc = it.pc;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      item_t it;
      @(negedge clk);
      req_valid_i = 1'b0;
      pc_i = pc_i + PC_W'(77); sreg_i = ~sreg_i; eq_i = ~eq_i;
      it.v = 1'b0; it.t = m_taken; it.pc = m_pc; it.req = "R11/R2 idle";
      q.push_back(it);
    end
  endtask

  // Monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() >= 2) begin
        item_t it;
        it = q.pop_front();
        chk({it.req, " valid"}, int'(res_valid_o), int'(it.v));
        chk({it.req, " taken"}, int'(taken_o), int'(it.t));
        chk({it.req, " pc"}, int'(next_pc_o), it.pc);
      end
    end
  end

  initial begin
    #2000000;
    bad++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(res_valid_o), 0);
    chk("R1 reset taken", int'(taken_o), 0);
    chk("R1 reset pc", int'(next_pc_o), 0);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    chk("R1 post-reset valid", int'(res_valid_o), 0);
    chk("R1 post-reset pc", int'(next_pc_o), 0);

    // R3 R6: equal alias = Z bit 1, polarity 1
    drive("R3 R6 eq taken", 0, 1'b1, 1, 8'b0000_0010, 8'h00, 8'h00, 1'b0, 5, 100, 1'b0);
    drive("R4 R6 eq not taken", 0, 1'b1, 1, 8'b1111_1101, 8'h00, 8'h00, 1'b0, 5, 100, 1'b0);
    // R6: same-or-higher = C clear (bit 0, pol 0); lower = C set
    drive("R6 same-or-higher", 0, 1'b0, 0, 8'b1111_1110, 8'h00, 8'h00, 1'b0, 20, 200, 1'b0);
    drive("R6 lower not taken", 0, 1'b1, 0, 8'b1111_1110, 8'h00, 8'h00, 1'b0, 20, 200, 1'b0);
    // R6: signed greater-or-equal = S (bit 4) clear; I flag at bit 7
    drive("R6 ge via S", 0, 1'b0, 4, 8'b1110_1111, 8'h00, 8'h00, 1'b0, -3, 300, 1'b0);
    drive("R6 I flag bit7", 0, 1'b1, 7, 8'b1000_0000, 8'h00, 8'h00, 1'b0, 1, 300, 1'b0);
    // R5: extremes with wrap
    drive("R5 min offset wrap", 0, 1'b1, 2, 8'h04, 8'h00, 8'h00, 1'b0, -64, 10, 1'b0);
    drive("R5 max offset wrap", 0, 1'b1, 2, 8'h04, 8'h00, 8'h00, 1'b0, 63, 1020, 1'b0);
    // R12: branch ignores two-word flag
    drive("R12 branch two-word", 0, 1'b0, 3, 8'h00, 8'h00, 8'h00, 1'b0, 7, 400, 1'b1);
    drive("R12 branch untaken two-word", 0, 1'b1, 3, 8'h00, 8'h00, 8'h00, 1'b0, 7, 400, 1'b1);
    idle(3);
    // R7 register-bit skips
    drive("R7 rb set two-word", 1, 1'b1, 5, 8'h00, 8'h20, 8'h00, 1'b0, 0, 500, 1'b1);
    drive("R7 rb clear one-word", 1, 1'b0, 5, 8'hFF, 8'hDF, 8'hFF, 1'b0, 0, 500, 1'b0);
    drive("R7 rb wrap", 1, 1'b1, 0, 8'h00, 8'h01, 8'h00, 1'b0, 0, 1022, 1'b1);
    // R10 untaken skips
    drive("R10 rb untaken two-word", 1, 1'b1, 6, 8'hFF, 8'h00, 8'hFF, 1'b1, 0, 600, 1'b1);
    // R8 I/O-bit skips; register byte contradicts
    drive("R8 io set", 2, 1'b1, 3, 8'h00, 8'h00, 8'h08, 1'b0, 0, 700, 1'b0);
    drive("R8 io untaken despite reg", 2, 1'b1, 3, 8'hFF, 8'hFF, 8'hF7, 1'b1, 0, 700, 1'b1);
    // R9 compare skips; pol/bit contradict
    drive("R9 eq taken", 3, 1'b0, 2, 8'hFF, 8'hFF, 8'hFF, 1'b1, 0, 800, 1'b1);
    drive("R9 eq not taken", 3, 1'b1, 2, 8'hFF, 8'hFF, 8'hFF, 1'b0, 0, 800, 1'b1);
    drive("R10 eq untaken one-word", 3, 1'b0, 0, 8'h00, 8'h00, 8'h00, 1'b0, 0, 1023, 1'b0);
    idle(4);
    @(negedge clk); #2;
    report();
  end
endmodule